// File: doc/BRIEF.md
# Wake-Up Down-Counter Timer

This block is a 16-bit one-shot wake-up timer that runs from a 32.768 kHz clock. Software controls it through a small single-cycle register port. Writing a non-zero value to the load register copies that value into the counter and starts it. Writing zero stops the counter and clears it. There is no separate enable bit.

The counter steps down once per clock (fine resolution) or once every 4096 clocks (coarse, 125 ms). When it reaches zero it raises a sticky expiry flag and stays at zero until the next load. It can also drive an interrupt line. A freeze pin or a freeze register bit holds both the counter and the prescaler without losing their values.

The register port has no back-pressure. A write with `reg_we` high is accepted on the rising clock edge where it is present. `reg_rdata` is a combinational view of the register that `reg_addr` selects.

Top module: `wkt_timer`

## Requirements
- R1: After reset the load, count, setup and flag registers all read 0, and `irq` is low.
- R2: A write of a non-zero value V to address 0 (load register) makes address 0 read V and address 1 (count) read V on the next cycle.
- R3: With setup bit 0 clear, a non-zero count decreases by exactly 1 on every clock edge.
- R4: With setup bit 0 set, a non-zero count decreases by 1 once every 4096 clocks. Every load write restarts the 4096-clock interval from zero.
- R5: A write of 0 to the load register forces the count to 0 on the next cycle and stops it, without setting the expiry flag.
- R6: When the count steps from 1 to 0, bit 0 of address 3 (flag register) becomes 1 in the same cycle. The count then stays at 0 until the next load write.
- R7: Writing a 1 to bit 0 of the flag register clears the flag, and writing a 0 there leaves it unchanged. An expiry in the same cycle as a clear leaves the flag set.
- R8: `irq` is high exactly while the expiry flag and setup bit 1 (address 2, interrupt enable) are both 1.
- R9: While `freeze_in` is high or setup bit 2 is set, the count and the prescaler hold their values. Counting resumes from the held values once both are clear.
- R10: A load write in the same cycle as a 1-to-0 step loads the new value and still sets the expiry flag.
- R11: Writes to address 1 (count) have no effect on any register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 32.768 kHz timer clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| freeze_in | input | 1 | Holds counter and prescaler while high |
| reg_we | input | 1 | Register write strobe, one cycle per write |
| reg_addr | input | 2 | Register select: 0 load, 1 count, 2 setup, 3 flag |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Read data for the register that `reg_addr` selects |
| irq | output | 1 | Expiry interrupt, level-sensitive |

## Verification
A bad counter state shows up at the count register read in the very next cycle: a skipped or doubled decrement changes the value read after a known number of edges. A bad prescaler state appears only at the next coarse step, so it can take up to 4096 clocks to be seen. The coarse tests therefore sample just before and just after the 4096th edge. A bad expiry flag is visible at once on `irq` when the interrupt is enabled, and it also shows in the flag register read.

// File: rtl/wkt_pkg.sv
package wkt_pkg;
  localparam int ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    A_LOAD  = 2'd0,
    A_COUNT = 2'd1,
    A_SETUP = 2'd2,
    A_FLAG  = 2'd3
  } wkt_addr_e;

  localparam int SETUP_COARSE = 0;
  localparam int SETUP_IEN    = 1;
  localparam int SETUP_FREEZE = 2;
  localparam int SETUP_W      = 3;

  typedef struct packed {
    logic freeze;
    logic ien;
    logic coarse;
  } wkt_setup_t;
endpackage

// File: rtl/wkt_regs.sv
module wkt_regs
  import wkt_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [CNT_W-1:0]  count_q,
  input  logic              flag_q,
  output wkt_setup_t        setup_q,
  output logic              load_wr,
  output logic [CNT_W-1:0]  load_val,
  output logic              flag_clr,
  output logic [DATA_W-1:0] rdata
);
  logic [CNT_W-1:0] load_q;

  assign load_wr  = we && (addr == A_LOAD);
  assign load_val = wdata[CNT_W-1:0];
  assign flag_clr = we && (addr == A_FLAG) && wdata[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      load_q  <= '0;
      setup_q <= '0;
    end else if (we) begin
      case (addr)
        A_LOAD:  load_q  <= load_val;
        A_SETUP: setup_q <= wdata[SETUP_W-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      A_LOAD:  rdata[CNT_W-1:0]   = load_q;
      A_COUNT: rdata[CNT_W-1:0]   = count_q;
      A_SETUP: rdata[SETUP_W-1:0] = setup_q;
      A_FLAG:  rdata[0]           = flag_q;
      default: rdata = '0;
    endcase
  end
endmodule

// File: rtl/wkt_prescaler.sv
module wkt_prescaler #(
  parameter int PRE_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             enable,
  output logic             tick,
  output logic [PRE_W-1:0] value
);
  localparam logic [PRE_W-1:0] LAST = {PRE_W{1'b1}};

  assign tick = enable && (value == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       value <= '0;
    else if (restart) value <= '0;
    else if (enable)  value <= value + 1'b1;
  end
endmodule

// File: rtl/wkt_counter.sv
module wkt_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             step,
  output logic [CNT_W-1:0] count_q,
  output logic             live,
  output logic             expire
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  assign live   = (count_q != '0);
  assign expire = step && (count_q == ONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             count_q <= '0;
    else if (load)          count_q <= load_val;
    else if (step && live)  count_q <= count_q - ONE;
  end
endmodule

// File: rtl/wkt_timer.sv
module wkt_timer
  import wkt_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int CNT_W  = 16,
  parameter int PRE_W  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              freeze_in,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq
);
  wkt_setup_t       setup_q;
  logic             load_wr;
  logic [CNT_W-1:0] load_val;
  logic             flag_clr;
  logic             flag_q;
  logic [CNT_W-1:0] count_q;
  logic             live;
  logic             expire;
  logic             frozen;
  logic             pre_en;
  logic             pre_tick;
  logic [PRE_W-1:0] pre_val;
  logic             step;

  wkt_regs #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .count_q(count_q), .flag_q(flag_q), .setup_q(setup_q), .load_wr(load_wr),
    .load_val(load_val), .flag_clr(flag_clr), .rdata(reg_rdata)
  );

  assign frozen = freeze_in || setup_q.freeze;
  assign pre_en = setup_q.coarse && !frozen && live;
  assign step   = !frozen && live && (setup_q.coarse ? pre_tick : 1'b1);

  wkt_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .restart(load_wr), .enable(pre_en),
    .tick(pre_tick), .value(pre_val)
  );

  wkt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .load(load_wr), .load_val(load_val),
    .step(step), .count_q(count_q), .live(live), .expire(expire)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        flag_q <= 1'b0;
    else if (expire)   flag_q <= 1'b1;
    else if (flag_clr) flag_q <= 1'b0;
  end

  assign irq = flag_q && setup_q.ien;
endmodule

// File: rtl/wkt_timer_chk.sv
module wkt_timer_chk #(
  parameter int DATA_W = 16,
  parameter int CNT_W  = 16,
  parameter int PRE_W  = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_we,
  input logic [1:0]        reg_addr,
  input logic [DATA_W-1:0] reg_wdata,
  input logic [CNT_W-1:0]  count_q,
  input logic              flag_q,
  input logic              irq,
  input logic              frozen,
  input logic              coarse,
  input logic [PRE_W-1:0]  pre_val
);
  logic ld;
  assign ld = reg_we && (reg_addr == 2'd0);

  a_r2_load_copies: assert property (@(posedge clk) disable iff (!rst_n)
    ld |=> count_q == $past(reg_wdata[CNT_W-1:0]));

  a_r3_fine_step: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld && !frozen && !coarse && count_q != '0) |=> count_q == $past(count_q) - 1'b1);

  a_r4_coarse_wait: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld && coarse && pre_val != {PRE_W{1'b1}}) |=> $stable(count_q));

  a_r6_stay_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld && count_q == '0) |=> count_q == '0);

  a_r6_flag_on_expiry: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld && count_q == CNT_W'(1) && !frozen && (!coarse || pre_val == {PRE_W{1'b1}}))
    |=> flag_q);

  a_r8_irq_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> flag_q);

  a_r9_freeze_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (frozen && !ld) |=> ($stable(count_q) && $stable(pre_val)));
endmodule

bind wkt_timer wkt_timer_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W), .PRE_W(PRE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .count_q(count_q), .flag_q(flag_q), .irq(irq),
  .frozen(frozen), .coarse(setup_q.coarse), .pre_val(pre_val)
);

// File: tb/tb_wkt_timer.sv
module tb_wkt_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        freeze_in = 1'b0;
  logic        reg_we = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        irq;
  int          n_chk = 0;
  int          n_bad = 0;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  wkt_timer dut (
    .clk(clk), .rst_n(rst_n), .freeze_in(freeze_in), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
  );

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    step(1);
    reg_we = 1'b0;
  endtask

  task automatic chk_reg(input string req, input logic [1:0] a, input logic [15:0] exp);
    reg_addr = a;
    #1;
    n_chk++;
    if (reg_rdata !== exp) begin
      n_bad++;
      $display("FAIL %s addr %0d: got %0h expected %0h", req, a, reg_rdata, exp);
    end
  endtask

  task automatic chk_irq(input string req, input logic exp);
    n_chk++;
    if (irq !== exp) begin
      n_bad++;
      $display("FAIL %s irq: got %b expected %b", req, irq, exp);
    end
  endtask

  task automatic t_reset;
    chk_reg("R1", 2'd0, 16'h0);
    chk_reg("R1", 2'd1, 16'h0);
    chk_reg("R1", 2'd2, 16'h0);
    chk_reg("R1", 2'd3, 16'h0);
    chk_irq("R1", 1'b0);
  endtask

  task automatic t_fine;
    wr(2'd0, 16'd5);
    chk_reg("R2", 2'd0, 16'd5);
    chk_reg("R2", 2'd1, 16'd5);
    step(1);
    chk_reg("R3", 2'd1, 16'd4);
    step(3);
    chk_reg("R3", 2'd1, 16'd1);
    chk_reg("R6", 2'd3, 16'd0);
    step(1);
    chk_reg("R6", 2'd1, 16'd0);
    chk_reg("R6", 2'd3, 16'd1);
    chk_irq("R8", 1'b0);
    step(10);
    chk_reg("R6", 2'd1, 16'd0);
  endtask

  task automatic t_flag_irq;
    wr(2'd3, 16'h0);
    chk_reg("R7", 2'd3, 16'd1);
    wr(2'd2, 16'h2);
    chk_irq("R8", 1'b1);
    wr(2'd3, 16'h1);
    chk_reg("R7", 2'd3, 16'd0);
    chk_irq("R8", 1'b0);
    wr(2'd0, 16'd3);
    step(2);
    wr(2'd3, 16'h1);
    chk_reg("R7", 2'd3, 16'd1);
    chk_irq("R8", 1'b1);
    wr(2'd3, 16'h1);
    wr(2'd2, 16'h0);
  endtask

  task automatic t_stop;
    wr(2'd0, 16'd100);
    step(3);
    chk_reg("R3", 2'd1, 16'd97);
    wr(2'd0, 16'd0);
    chk_reg("R5", 2'd1, 16'd0);
    chk_reg("R5", 2'd0, 16'd0);
    step(5);
    chk_reg("R5", 2'd1, 16'd0);
    chk_reg("R5", 2'd3, 16'd0);
  endtask

  task automatic t_collide;
    wr(2'd0, 16'd3);
    step(2);
    wr(2'd0, 16'd7);
    chk_reg("R10", 2'd1, 16'd7);
    chk_reg("R10", 2'd3, 16'd1);
    wr(2'd0, 16'd0);
    wr(2'd3, 16'h1);
  endtask

  task automatic t_freeze;
    wr(2'd0, 16'd10);
    step(2);
    freeze_in = 1'b1;
    step(5);
    chk_reg("R9", 2'd1, 16'd8);
    freeze_in = 1'b0;
    step(3);
    chk_reg("R9", 2'd1, 16'd5);
    wr(2'd2, 16'h4);
    step(4);
    chk_reg("R9", 2'd1, 16'd4);
    wr(2'd2, 16'h0);
    step(2);
    chk_reg("R9", 2'd1, 16'd2);
    wr(2'd0, 16'd0);
  endtask

  task automatic t_coarse;
    wr(2'd2, 16'h1);
    wr(2'd0, 16'd2);
    step(4095);
    chk_reg("R4", 2'd1, 16'd2);
    step(1);
    chk_reg("R4", 2'd1, 16'd1);
    step(2000);
    wr(2'd0, 16'd3);
    step(4095);
    chk_reg("R4", 2'd1, 16'd3);
    step(1);
    chk_reg("R4", 2'd1, 16'd2);
    freeze_in = 1'b1;
    step(5000);
    freeze_in = 1'b0;
    step(4095);
    chk_reg("R9", 2'd1, 16'd2);
    step(1);
    chk_reg("R9", 2'd1, 16'd1);
    wr(2'd0, 16'd0);
    wr(2'd2, 16'h0);
  endtask

  task automatic t_count_ro;
    wr(2'd1, 16'h1234);
    chk_reg("R11", 2'd1, 16'd0);
    chk_reg("R11", 2'd0, 16'd0);
    chk_reg("R11", 2'd2, 16'd0);
    chk_reg("R11", 2'd3, 16'd0);
  endtask

  initial begin
    #1;
    step(3);
    rst_n = 1'b1;
    step(1);
    t_reset();
    t_fine();
    t_flag_irq();
    t_stop();
    t_collide();
    t_freeze();
    t_count_ro();
    t_coarse();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #2_000_000;
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule